// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in a receive path and decides, from the first six bytes of each frame, whether the frame is kept or dropped. Bytes arrive one per valid cycle, and a start marker flags the first byte of each frame. As the destination address streams in, the block builds the address and a CRC-32 over it. One cycle after the sixth byte it presents a decision that stays steady until the next frame begins.

Software programs the filter through a small word-addressed register port. The programmable settings are a station address, six enable bits and two 128-bit hash tables, one for unicast and one for group addresses. The block also records the source address (bytes 6 to 11) of the most recent frame, and software can read it back through the same port.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0 and every register reads 0.
- R2: The register map uses word addresses. Address 0 is the control register with enable bits [5:0]. Address 1 holds station bytes 0 and 1 in bits 15:8 and 7:0. Address 2 holds station bytes 2..5, with byte 2 in 31:24 and byte 5 in 7:0. Addresses 3..6 are unicast hash words 0..3 and addresses 7..10 are group hash words 0..3. Every written value reads back unchanged, and unused bits read 0.
- R3: `dec_valid` rises in the cycle after the sixth valid byte of a frame. It stays 1, with `dec_accept` constant, until the cycle after the next start byte, when both return to 0.
- R4: Control bit 2 enables exact match. A frame whose destination equals the station address is accepted.
- R5: Control bit 3 enables broadcast. A destination of all ones is accepted.
- R6: Control bit 4 enables group hashing. A group destination (bit 0 of byte 0 set) that is not broadcast is accepted when the selected group hash bit is 1. The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, LSB of each byte first, final value inverted) over bytes 0..5. The index is bits 31:25 of that CRC. Index bits 6:5 select the word and index bits 4:0 select the bit.
- R7: Control bit 5 enables unicast hashing. A destination with bit 0 of byte 0 clear is accepted when the unicast hash bit it selects is 1, using the same index as R6.
- R8: Control bit 0 (promiscuous) accepts every frame.
- R9: Control bit 1 (promiscuous group) accepts every group destination, broadcast included. It has no effect on unicast destinations.
- R10: When byte 11 of a frame arrives, the source address is stored. Address 11 reads bytes 6 and 7 in bits 15:8 and 7:0. Address 12 reads bytes 8..11, with byte 8 in 31:24. Writes to addresses 11 and 12 have no effect.
- R11: A frame matched by no enabled rule is rejected. With control equal to 0, every frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Accept (1) or reject (0) the current frame |

## Verification
A wrong running CRC or a misplaced address byte stays hidden inside the block until the sixth byte. It then appears as a wrong `dec_accept` in the very next cycle. Random destinations checked against hash tables that are half full make such faults visible within a few frames. A byte counter that is off by one shows up as `dec_valid` rising one byte early or late. It also shows up as a shifted source address when the source registers are read back at the end of the frame.

// File: rtl/dst_addr_filter.sv
module dst_addr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_data,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        dec_valid,
  output logic        dec_accept
);

  localparam logic [3:0] POS_DONE = 4'd12;

  logic [5:0]  ctl;
  logic [15:0] sta_hi;
  logic [31:0] sta_lo;
  logic [31:0] uhash [4];
  logic [31:0] ghash [4];
  logic [15:0] lsa_hi;
  logic [31:0] lsa_lo;

  logic [3:0]  cnt;
  logic [39:0] da_q;
  logic [39:0] sa_q;
  logic [31:0] crc_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [3:0]  pos;
  logic [31:0] crc_in, crc_nx, crc_fin;
  logic [47:0] da_full;
  logic [6:0]  hidx;
  logic        is_grp, is_bc, st_hit, uh_hit, gh_hit, acc;

  assign pos     = rx_sof ? 4'd0 : cnt;
  assign crc_in  = (pos == 4'd0) ? 32'hFFFFFFFF : crc_q;
  assign crc_nx  = crc_step(crc_in, rx_data);
  assign crc_fin = ~crc_nx;
  assign hidx    = crc_fin[31:25];
  assign da_full = {da_q, rx_data};
  assign is_grp  = da_full[40];
  assign is_bc   = &da_full;
  assign st_hit  = da_full == {sta_hi, sta_lo};
  assign uh_hit  = uhash[hidx[6:5]][hidx[4:0]];
  assign gh_hit  = ghash[hidx[6:5]][hidx[4:0]];

  always_comb begin
    acc = ctl[0];
    if (is_grp) begin
      if (ctl[1])                    acc = 1'b1;
      if (is_bc && ctl[3])           acc = 1'b1;
      if (!is_bc && ctl[4] && gh_hit) acc = 1'b1;
    end else begin
      if (ctl[2] && st_hit)          acc = 1'b1;
      if (ctl[5] && uh_hit)          acc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= POS_DONE;
      da_q       <= '0;
      sa_q       <= '0;
      crc_q      <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      lsa_hi     <= '0;
      lsa_lo     <= '0;
    end else if (rx_valid) begin
      if (pos < POS_DONE) cnt <= pos + 4'd1;
      if (pos < 4'd6) begin
        crc_q <= crc_nx;
        da_q  <= {da_q[31:0], rx_data};
      end else if (pos < 4'd11) begin
        sa_q <= {sa_q[31:0], rx_data};
      end else if (pos == 4'd11) begin
        lsa_hi <= sa_q[39:24];
        lsa_lo <= {sa_q[23:0], rx_data};
      end
      if (rx_sof) begin
        dec_valid  <= 1'b0;
        dec_accept <= 1'b0;
      end else if (pos == 4'd5) begin
        dec_valid  <= 1'b1;
        dec_accept <= acc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      sta_hi <= '0;
      sta_lo <= '0;
      for (int i = 0; i < 4; i++) begin
        uhash[i] <= '0;
        ghash[i] <= '0;
      end
    end else if (reg_wr) begin
      case (reg_addr)
        4'd0:  ctl    <= reg_wdata[5:0];
        4'd1:  sta_hi <= reg_wdata[15:0];
        4'd2:  sta_lo <= reg_wdata;
        4'd3, 4'd4, 4'd5, 4'd6:  uhash[reg_addr[1:0] - 2'd3] <= reg_wdata;
        4'd7, 4'd8, 4'd9, 4'd10: ghash[reg_addr[1:0] - 2'd3] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:  reg_rdata = {26'd0, ctl};
      4'd1:  reg_rdata = {16'd0, sta_hi};
      4'd2:  reg_rdata = sta_lo;
      4'd3, 4'd4, 4'd5, 4'd6:  reg_rdata = uhash[reg_addr[1:0] - 2'd3];
      4'd7, 4'd8, 4'd9, 4'd10: reg_rdata = ghash[reg_addr[1:0] - 2'd3];
      4'd11: reg_rdata = {16'd0, lsa_hi};
      4'd12: reg_rdata = lsa_lo;
      default: reg_rdata = '0;
    endcase
  end

  AST_VALID_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_sof && cnt == 4'd5 |=> dec_valid) else $error("AST_VALID_AFTER_SIXTH"); // R3
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sof |=> !dec_valid && !dec_accept) else $error("AST_SOF_CLEARS"); // R3
  AST_DECISION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(dec_valid) |-> $stable(dec_accept)) else $error("AST_DECISION_HOLDS"); // R3
  AST_PROM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && $past(ctl[0]) |-> dec_accept) else $error("AST_PROM_ALL"); // R8
  AST_ALL_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && $past(ctl) == 6'd0 |-> !dec_accept) else $error("AST_ALL_OFF_REJECTS"); // R11
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid) else $error("AST_ACCEPT_NEEDS_VALID"); // R3

endmodule

// File: tb/dst_addr_filter_test.sv
module dst_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int errors = 0;

  logic [5:0]  m_ctl = '0;
  logic [47:0] m_sta = '0;
  logic [31:0] m_uh [4];
  logic [31:0] m_gh [4];

  always #5 clk = ~clk;

  dst_addr_filter uut (.*);

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] hash_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = da[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ by[i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    return c[31:25];
  endfunction

  function automatic logic expect_accept(input logic [47:0] da);
    logic [6:0] ix = hash_idx(da);
    logic grp = da[40];
    logic bc = &da;
    if (m_ctl[0]) return 1'b1;
    if (grp) begin
      if (m_ctl[1]) return 1'b1;
      if (bc && m_ctl[3]) return 1'b1;
      if (!bc && m_ctl[4] && m_gh[ix[6:5]][ix[4:0]]) return 1'b1;
      return 1'b0;
    end
    if (m_ctl[2] && da == m_sta) return 1'b1;
    if (m_ctl[5] && m_uh[ix[6:5]][ix[4:0]]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      4'd0: m_ctl = d[5:0];
      4'd1: m_sta[47:32] = d[15:0];
      4'd2: m_sta[31:0] = d;
      4'd3, 4'd4, 4'd5, 4'd6:  m_uh[a - 4'd3] = d;
      4'd7, 4'd8, 4'd9, 4'd10: m_gh[a - 4'd7] = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  task automatic send(input string req, input logic [47:0] da, input logic [47:0] sa,
                      input int pay, input bit gaps);
    logic exp = expect_accept(da);
    for (int i = 0; i < 12 + pay; i++) begin
      if (gaps) begin
        int g = $urandom % 3;
        for (int k = 0; k < g; k++) begin
          @(negedge clk); rx_valid = 1'b0;
        end
      end
      @(negedge clk);
      if (i >= 1 && i <= 5) check("R3 early valid", {47'd0, dec_valid}, 48'd0);
      if (i == 6) begin
        check("R3 valid after sixth", {47'd0, dec_valid}, 48'd1);
        check(req, {47'd0, dec_accept}, {47'd0, exp});
      end
      rx_valid = 1'b1;
      rx_sof = (i == 0);
      if (i < 6) rx_data = da[47 - 8*i -: 8];
      else if (i < 12) rx_data = sa[47 - 8*(i-6) -: 8];
      else rx_data = 8'($urandom);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    @(negedge clk);
    check("R3 hold valid", {46'd0, dec_valid, dec_accept}, {46'd0, 1'b1, exp});
    rd_check("R10 sa hi", 4'd11, {16'd0, sa[47:32]});
    rd_check("R10 sa lo", 4'd12, sa[31:0]);
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] da;
    logic [6:0]  ix;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin m_uh[i] = '0; m_gh[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {46'd0, dec_valid, dec_accept}, 48'd0);
    for (int a = 0; a < 13; a++) rd_check("R1 reset regs", 4'(a), 32'd0);

    wr(4'd1, 32'hFFFF_0A1B);
    wr(4'd2, 32'h2C3D_4E5F);
    rd_check("R2 station hi", 4'd1, 32'h0000_0A1B);
    rd_check("R2 station lo", 4'd2, 32'h2C3D_4E5F);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check("R2 ctl", 4'd0, 32'h3F);
    for (int a = 3; a < 11; a++) begin
      logic [31:0] v = $urandom;
      wr(4'(a), v);
      rd_check("R2 hash words", 4'(a), v);
    end

    wr(4'd0, 32'd0);
    send("R11 broadcast off", 48'hFFFF_FFFF_FFFF, rnd48(), 2, 0);
    send("R11 station off", m_sta, rnd48(), 0, 0);
    wr(4'd11, 32'hDEAD_BEEF);
    wr(4'd12, 32'hDEAD_BEEF);
    send("R10 write ignored", 48'h0200_0000_0001, 48'h1122_3344_5566, 0, 0);
    wr(4'd0, 32'h4);
    send("R4 station", m_sta, rnd48(), 1, 1);
    send("R4 near miss", m_sta ^ 48'h1, rnd48(), 1, 1);
    wr(4'd0, 32'h8);
    send("R5 broadcast", 48'hFFFF_FFFF_FFFF, rnd48(), 0, 0);
    wr(4'd0, 32'h1);
    send("R8 promiscuous", 48'h0212_3456_789A, rnd48(), 0, 0);
    wr(4'd0, 32'h2);
    send("R9 prom group", 48'h0112_3456_789A, rnd48(), 0, 0);
    send("R9 prom group unicast", 48'h0212_3456_789A, rnd48(), 0, 0);

    da = 48'h0100_5E00_0001;
    ix = hash_idx(da);
    for (int i = 0; i < 4; i++) wr(4'(7 + i), 32'd0);
    wr(4'd0, 32'h10);
    send("R6 group hash miss", da, rnd48(), 0, 0);
    wr(4'(7 + ix[6:5]), 32'd1 << ix[4:0]);
    send("R6 group hash hit", da, rnd48(), 0, 0);
    da = 48'h0250_AA00_1234;
    ix = hash_idx(da);
    for (int i = 0; i < 4; i++) wr(4'(3 + i), 32'd0);
    wr(4'd0, 32'h20);
    send("R7 unicast hash miss", da, rnd48(), 0, 0);
    wr(4'(3 + ix[6:5]), 32'd1 << ix[4:0]);
    send("R7 unicast hash hit", da, rnd48(), 0, 0);

    for (int n = 0; n < 300; n++) begin
      int kind = $urandom % 5;
      if ($urandom % 4 == 0) wr(4'd0, $urandom);
      if (n % 60 == 0) for (int a = 3; a < 11; a++) wr(4'(a), $urandom);
      case (kind)
        0: da = m_sta;
        1: da = 48'hFFFF_FFFF_FFFF;
        2: begin da = rnd48(); da[40] = 1'b0; end
        3: begin da = rnd48(); da[40] = 1'b1; if (&da) da[0] = 1'b0; end
        default: da = m_sta ^ (48'd1 << ($urandom % 48));
      endcase
      send("R4 R5 R6 R7 R8 R9 R11 random", da, rnd48(), $urandom % 4, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule